// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Block

This block collects 64 level-driven interrupt lines into two processor requests. A fast request is raised for sources marked fast, and a normal request is raised for sources marked normal. Each source has a pending bit, an enable bit, a type bit and a 4-bit priority. Software reaches all of this state through a 32-bit register file that is addressed by word index, with separate read and write strobes. A change on an input line is registered as an edge. A rise sets the pending bit and a fall clears it. Software can also overwrite the pending vector directly.

A handler finds the source to serve by reading one of two vector words. The normal vector word returns the highest-priority eligible normal source, and a tie goes to the higher source number. The fast vector word returns the lowest-numbered eligible fast source. Either read also clears the pending bit of the source it returns. The normal request is gated by a 5-bit threshold. All-ones in the threshold lets any eligible normal source through. Any other value requires a source whose priority is strictly greater than the threshold.

Top module: `vic_regblock`

## Requirements
- R1: A 0-to-1 change on `src_i[n]` sets pending bit n and a 1-to-0 change clears it. The pending vector reads raw at word 18 (bits 63:32) and word 19 (bits 31:0).
- R2: Writing n to word 2 sets enable bit n, and writing n to word 3 clears it. This happens only when the write data is below 64; other values leave the enables unchanged. Words 2 and 3 read as 0.
- R3: Words 5 and 4 read and write enable bits 31:0 and 63:32. Words 7 and 6 do the same for the type vector, where 1 marks a fast source.
- R4: Word 1 keeps only bits 4:0 of a write as the normal threshold. Word 0 is a 32-bit control word that reads back as written.
- R5: Word 15 - k holds priority word k, for k from 0 to 7. Source n's 4-bit priority is bits 4*(n%8)+3 : 4*(n%8) of priority word n/8.
- R6: `irq_fast_o` equals the OR over all sources of pending AND enable AND type, taken from the state one cycle earlier.
- R7: `irq_norm_o` is 1 one cycle after the following state: some source is pending, enabled and not fast, and either the threshold is 31 or one such source has a priority strictly above the threshold. Otherwise the output is 0.
- R8: Reading word 16 returns {source number[15:0], priority[15:0]} of the eligible normal source with the highest priority, the higher number winning ties, and clears its pending bit. With none eligible it returns 0xFFFFFFFF.
- R9: Reading word 17 returns the lowest-numbered source that is pending, enabled and fast, and clears its pending bit. With none it returns 0xFFFFFFFF.
- R10: Writes to word 20 and word 21 overwrite pending bits 63:32 and 31:0. Words 22/23 read pending AND enable AND NOT type, and words 24/25 read pending AND enable AND type, high half first. Writes to words 16-19 and 22-25 change nothing.
- R11: Reset clears pending, enable, type, control, threshold, all priority words and both outputs.
- R12: Read data appears on `rdata_o` after the clock edge that samples `rd_en_i`. A vector-read acknowledge beats a rising input edge on the same source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 64 | Interrupt lines, one per source |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 7 | Word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_fast_o | output | 1 | Fast interrupt request |

## Verification
Corrupt pending, enable or type state shows up at the request outputs one cycle after it happens. It also shows in the raw and filtered pending words on the next read. A wrong priority field or a wrong tie rule stays hidden until a vector read returns the wrong source number. When that happens, the wrong source's pending bit is also cleared, so the error carries into the next read and into the next request level. The bench therefore reads vectors back to back after overlapping raises and checks that the queue drains in the expected order.

// File: rtl/vic_pkg.sv
// Package: shared sizes and register word indices for the interrupt
// controller. Assumes a 32-bit data word and a 64-source map split in
// two halves.
package vic_pkg;
    localparam int NUM_SRC       = 64;
    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 7;
    localparam int PRIO_W        = 4;
    localparam int MASK_W        = 5;
    localparam int IDX_W         = $clog2(NUM_SRC);
    localparam int PRIO_PER_WORD = DATA_W / PRIO_W;
    localparam int PRIO_WORDS    = NUM_SRC / PRIO_PER_WORD;

    localparam logic [ADDR_W-1:0] W_CTRL    = 7'd0;
    localparam logic [ADDR_W-1:0] W_THRESH  = 7'd1;
    localparam logic [ADDR_W-1:0] W_EN_NUM  = 7'd2;
    localparam logic [ADDR_W-1:0] W_DIS_NUM = 7'd3;
    localparam logic [ADDR_W-1:0] W_EN_HI   = 7'd4;
    localparam logic [ADDR_W-1:0] W_EN_LO   = 7'd5;
    localparam logic [ADDR_W-1:0] W_TY_HI   = 7'd6;
    localparam logic [ADDR_W-1:0] W_TY_LO   = 7'd7;
    localparam logic [ADDR_W-1:0] W_PRIO_LO = 7'd8;
    localparam logic [ADDR_W-1:0] W_PRIO_HI = 7'd15;
    localparam logic [ADDR_W-1:0] W_NVEC    = 7'd16;
    localparam logic [ADDR_W-1:0] W_FVEC    = 7'd17;
    localparam logic [ADDR_W-1:0] W_RAW_HI  = 7'd18;
    localparam logic [ADDR_W-1:0] W_RAW_LO  = 7'd19;
    localparam logic [ADDR_W-1:0] W_FRC_HI  = 7'd20;
    localparam logic [ADDR_W-1:0] W_FRC_LO  = 7'd21;
    localparam logic [ADDR_W-1:0] W_NP_HI   = 7'd22;
    localparam logic [ADDR_W-1:0] W_NP_LO   = 7'd23;
    localparam logic [ADDR_W-1:0] W_FP_HI   = 7'd24;
    localparam logic [ADDR_W-1:0] W_FP_LO   = 7'd25;

    localparam logic [DATA_W-1:0] NO_VECTOR = '1;
endpackage

// File: rtl/vic_src_state.sv
// Module: pending-bit store. Edge-detects each input line, applies
// software overwrites of either half and clears the acknowledged source.
// Assumes NUM_SRC equals twice the data width.
module vic_src_state #(
    parameter int NUM_SRC = vic_pkg::NUM_SRC,
    parameter int DATA_W  = vic_pkg::DATA_W,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int HALF   = NUM_SRC / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               frc_hi_we,
    input  logic               frc_lo_we,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               ack_en,
    input  logic [IDX_W-1:0]   ack_idx,
    output logic [NUM_SRC-1:0] pending
);
    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] fall;
    logic [NUM_SRC-1:0] pend_nxt;

    // Remember the previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    assign rise = src_i & ~src_q;
    assign fall = ~src_i & src_q;

    // Next pending value: edges, then overwrite, then acknowledge (highest).
    always_comb begin
        pend_nxt = (pending | rise) & ~fall;
        if (frc_hi_we) pend_nxt[NUM_SRC-1:HALF] = wdata[HALF-1:0];
        if (frc_lo_we) pend_nxt[HALF-1:0]       = wdata[HALF-1:0];
        if (ack_en)    pend_nxt[ack_idx]        = 1'b0;
    end

    // Pending register.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else        pending <= pend_nxt;
    end
endmodule

// File: rtl/vic_cfg_regs.sv
// Module: software-visible configuration: control word, threshold,
// enable vector (by number or by half), type vector and priority words.
// Assumes the word indices defined in vic_pkg.
module vic_cfg_regs
    import vic_pkg::*;
#(
    parameter int NUM_SRC = vic_pkg::NUM_SRC,
    parameter int PW      = vic_pkg::PRIO_W,
    parameter int MW      = vic_pkg::MASK_W,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int HALF   = NUM_SRC / 2,
    localparam int NWORDS = NUM_SRC * PW / DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     ctrl,
    output logic [MW-1:0]         thresh,
    output logic [NUM_SRC-1:0]    enable,
    output logic [NUM_SRC-1:0]    ftype,
    output logic [NUM_SRC*PW-1:0] prio_flat
);
    logic [DATA_W-1:0] prio_q [NWORDS];
    logic              num_ok;
    logic [IDX_W-1:0]  num;

    assign num    = wdata[IDX_W-1:0];
    assign num_ok = (wdata[DATA_W-1:IDX_W] == '0);

    // Control word and threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '0;
            thresh <= '0;
        end else if (wr_en) begin
            if (addr == W_CTRL)   ctrl   <= wdata;
            if (addr == W_THRESH) thresh <= wdata[MW-1:0];
        end
    end

    // Enable vector: set/clear by number or replace a half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
        end else if (wr_en) begin
            case (addr)
                W_EN_NUM:  if (num_ok) enable[num] <= 1'b1;
                W_DIS_NUM: if (num_ok) enable[num] <= 1'b0;
                W_EN_HI:   enable[NUM_SRC-1:HALF] <= wdata[HALF-1:0];
                W_EN_LO:   enable[HALF-1:0]       <= wdata[HALF-1:0];
                default:   ;
            endcase
        end
    end

    // Type vector halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftype <= '0;
        end else if (wr_en) begin
            if (addr == W_TY_HI) ftype[NUM_SRC-1:HALF] <= wdata[HALF-1:0];
            if (addr == W_TY_LO) ftype[HALF-1:0]       <= wdata[HALF-1:0];
        end
    end

    // One priority word per generate slot; word index runs reversed.
    for (genvar w = 0; w < NWORDS; w++) begin : g_prio
        localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(int'(W_PRIO_LO) + NWORDS - 1 - w);
        // Priority word w storage.
        always_ff @(posedge clk) begin
            if (!rst_n)                     prio_q[w] <= '0;
            else if (wr_en && addr == SLOT) prio_q[w] <= wdata;
        end
        assign prio_flat[w*DATA_W +: DATA_W] = prio_q[w];
    end
endmodule

// File: rtl/vic_norm_resolver.sv
// Module: picks the highest-priority eligible normal source (higher
// number wins ties) and decides whether the threshold lets a request out.
// Purely combinational.
module vic_norm_resolver #(
    parameter int NUM_SRC = vic_pkg::NUM_SRC,
    parameter int PW      = vic_pkg::PRIO_W,
    parameter int MW      = vic_pkg::MASK_W,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]    elig,
    input  logic [NUM_SRC*PW-1:0] prio_flat,
    input  logic [MW-1:0]         thresh,
    output logic                  hit,
    output logic [IDX_W-1:0]      idx,
    output logic [PW-1:0]         prio,
    output logic                  req
);
    logic          above;
    logic [PW-1:0] cur;

    // Linear scan upward; >= lets later (higher) sources win ties.
    always_comb begin
        hit   = 1'b0;
        idx   = '0;
        prio  = '0;
        above = 1'b0;
        cur   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            cur = prio_flat[i*PW +: PW];
            if (elig[i]) begin
                if (!hit || cur >= prio) begin
                    prio = cur;
                    idx  = IDX_W'(i);
                end
                hit = 1'b1;
                if (MW'(cur) > thresh) above = 1'b1;
            end
        end
    end

    assign req = hit && ((thresh == {MW{1'b1}}) || above);
endmodule

// File: rtl/vic_fast_picker.sv
// Module: finds the lowest-numbered eligible fast source. Combinational.
module vic_fast_picker #(
    parameter int NUM_SRC = vic_pkg::NUM_SRC,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] elig,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);
    // Downward scan so the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |elig;
endmodule

// File: rtl/vic_regblock.sv
// Module: top of the interrupt controller. Decodes the word-addressed
// register interface, builds registered read data, issues vector-read
// acknowledges and registers both request outputs.
// Assumes single-cycle strobes; read data is valid after the sampling edge.
module vic_regblock
    import vic_pkg::*;
#(
    parameter int NUM_SRC = vic_pkg::NUM_SRC,
    parameter int PW      = vic_pkg::PRIO_W,
    parameter int MW      = vic_pkg::MASK_W,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int HALF   = NUM_SRC / 2,
    localparam int NWORDS = NUM_SRC * PW / DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               rd_en_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               irq_norm_o,
    output logic               irq_fast_o
);
    logic [NUM_SRC-1:0]    pending, enable, ftype;
    logic [NUM_SRC-1:0]    norm_elig, fast_elig;
    logic [NUM_SRC*PW-1:0] prio_flat;
    logic [DATA_W-1:0]     ctrl;
    logic [MW-1:0]         thresh;
    logic                  norm_hit, norm_req, fast_hit;
    logic [IDX_W-1:0]      norm_idx, fast_idx, ack_idx;
    logic [PW-1:0]         norm_prio;
    logic                  norm_ack, fast_ack;
    logic [DATA_W-1:0]     rd_mux;
    logic [DATA_W-1:0]     prio_word;

    assign norm_elig = pending & enable & ~ftype;
    assign fast_elig = pending & enable & ftype;

    assign norm_ack = rd_en_i && (addr_i == W_NVEC) && norm_hit;
    assign fast_ack = rd_en_i && (addr_i == W_FVEC) && fast_hit;
    assign ack_idx  = norm_ack ? norm_idx : fast_idx;

    vic_src_state #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .frc_hi_we (wr_en_i && addr_i == W_FRC_HI),
        .frc_lo_we (wr_en_i && addr_i == W_FRC_LO),
        .wdata     (wdata_i),
        .ack_en    (norm_ack || fast_ack),
        .ack_idx   (ack_idx),
        .pending   (pending)
    );

    vic_cfg_regs #(.NUM_SRC(NUM_SRC), .PW(PW), .MW(MW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en_i),
        .addr      (addr_i),
        .wdata     (wdata_i),
        .ctrl      (ctrl),
        .thresh    (thresh),
        .enable    (enable),
        .ftype     (ftype),
        .prio_flat (prio_flat)
    );

    vic_norm_resolver #(.NUM_SRC(NUM_SRC), .PW(PW), .MW(MW)) u_norm (
        .elig      (norm_elig),
        .prio_flat (prio_flat),
        .thresh    (thresh),
        .hit       (norm_hit),
        .idx       (norm_idx),
        .prio      (norm_prio),
        .req       (norm_req)
    );

    vic_fast_picker #(.NUM_SRC(NUM_SRC)) u_fast (
        .elig (fast_elig),
        .hit  (fast_hit),
        .idx  (fast_idx)
    );

    // Select the priority word addressed in the reversed window.
    always_comb begin
        prio_word = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (addr_i == ADDR_W'(int'(W_PRIO_LO) + NWORDS - 1 - w))
                prio_word = prio_flat[w*DATA_W +: DATA_W];
        end
    end

    // Read multiplexer over all defined words; unknown words read zero.
    always_comb begin
        rd_mux = '0;
        case (addr_i)
            W_CTRL:   rd_mux = ctrl;
            W_THRESH: rd_mux = DATA_W'(thresh);
            W_EN_HI:  rd_mux = enable[NUM_SRC-1:HALF];
            W_EN_LO:  rd_mux = enable[HALF-1:0];
            W_TY_HI:  rd_mux = ftype[NUM_SRC-1:HALF];
            W_TY_LO:  rd_mux = ftype[HALF-1:0];
            W_NVEC:   rd_mux = norm_hit ? {16'(norm_idx), 16'(norm_prio)} : NO_VECTOR;
            W_FVEC:   rd_mux = fast_hit ? DATA_W'(fast_idx) : NO_VECTOR;
            W_RAW_HI: rd_mux = pending[NUM_SRC-1:HALF];
            W_RAW_LO: rd_mux = pending[HALF-1:0];
            W_NP_HI:  rd_mux = norm_elig[NUM_SRC-1:HALF];
            W_NP_LO:  rd_mux = norm_elig[HALF-1:0];
            W_FP_HI:  rd_mux = fast_elig[NUM_SRC-1:HALF];
            W_FP_LO:  rd_mux = fast_elig[HALF-1:0];
            default:  rd_mux = prio_word;
        endcase
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_o <= '0;
        else if (rd_en_i) rdata_o <= rd_mux;
    end

    // Registered request outputs, re-evaluated from current state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_norm_o <= 1'b0;
            irq_fast_o <= 1'b0;
        end else begin
            irq_norm_o <= norm_req;
            irq_fast_o <= fast_hit;
        end
    end
endmodule

// File: rtl/vic_regblock_chk.sv
// Checker: temporal properties of the interrupt controller, bound into
// the top module. Observes ports and the state of the submodules.
module vic_regblock_chk
    import vic_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en_i,
    input logic               wr_en_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [DATA_W-1:0]  rdata_o,
    input logic               irq_norm_o,
    input logic               irq_fast_o,
    input logic [NUM_SRC-1:0] pending,
    input logic [NUM_SRC-1:0] enable,
    input logic [NUM_SRC-1:0] ftype,
    input logic               norm_hit,
    input logic [IDX_W-1:0]   norm_idx,
    input logic               fast_hit,
    input logic [IDX_W-1:0]   fast_idx
);
    AST_FAST_FOLLOWS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_fast_o == $past(|(pending & enable & ftype)))); // R6
    AST_NORM_QUIET_WHEN_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending & enable & ~ftype) == '0) |=> !irq_norm_o); // R7
    AST_NUM_WORDS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (addr_i == W_EN_NUM || addr_i == W_DIS_NUM)) |=> (rdata_o == '0)); // R2
    AST_NORM_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !wr_en_i && addr_i == W_NVEC && norm_hit) |=> !pending[$past(norm_idx)]); // R8
    AST_FAST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !wr_en_i && addr_i == W_FVEC && fast_hit) |=> !pending[$past(fast_idx)]); // R9
    AST_FAST_EMPTY_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == W_FVEC && !fast_hit) |=> (rdata_o == NO_VECTOR)); // R9
endmodule

bind vic_regblock vic_regblock_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .rdata_o    (rdata_o),
    .irq_norm_o (irq_norm_o),
    .irq_fast_o (irq_fast_o),
    .pending    (pending),
    .enable     (enable),
    .ftype      (ftype),
    .norm_hit   (norm_hit),
    .norm_idx   (norm_idx),
    .fast_hit   (fast_hit),
    .fast_idx   (fast_idx)
);

// File: tb/vic_regblock_tb_top.sv
// Bench: scoreboard. Read tasks queue expected words; a monitor pops
// and compares one cycle after each sampled read strobe.
module vic_regblock_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_norm, irq_fast;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    logic  rd_d = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    vic_regblock dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_norm_o(irq_norm), .irq_fast_o(irq_fast)
    );

    // Track which cycles carried a sampled read.
    always @(posedge clk) rd_d <= rd_en;

    // Monitor: compare read data against the queued expectation.
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if (rdata !== e) begin
                miscompares++;
                $display("FAIL %s rdata act=%h exp=%h", t, rdata, e);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk(input string t, input logic act, input logic e);
        vectors++;
        if (act !== e) begin
            miscompares++;
            $display("FAIL %s act=%0b exp=%0b", t, act, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one miscompare.
    initial begin
        #400000;
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R11: reset state
        chk("R11 irq_norm", irq_norm, 1'b0);
        chk("R11 irq_fast", irq_fast, 1'b0);
        rd(7'd4, 32'h0, "R11 enable hi");
        rd(7'd5, 32'h0, "R11 enable lo");
        rd(7'd19, 32'h0, "R11 pending lo");
        rd(7'd15, 32'h0, "R11 prio word0");
        rd(7'd1, 32'h0, "R11 thresh");
        rd(7'd0, 32'h0, "R11 ctrl");

        // R2: enable/disable by number
        wr(7'd2, 32'd5);
        wr(7'd2, 32'd40);
        rd(7'd5, 32'h20, "R2 enable src5");
        rd(7'd4, 32'h100, "R2 enable src40");
        rd(7'd2, 32'h0, "R2 word2 reads zero");
        rd(7'd3, 32'h0, "R2 word3 reads zero");
        wr(7'd3, 32'd5);
        rd(7'd5, 32'h0, "R2 disable src5");
        wr(7'd2, 32'd100);
        rd(7'd4, 32'h100, "R2 out-of-range hi unchanged");
        rd(7'd5, 32'h0, "R2 out-of-range lo unchanged");

        // R3: half-word enable and type
        wr(7'd5, 32'hFFFF_FFFF);
        rd(7'd5, 32'hFFFF_FFFF, "R3 enable lo");
        wr(7'd6, 32'hA5A5_0000);
        rd(7'd6, 32'hA5A5_0000, "R3 type hi");
        wr(7'd6, 32'h0);
        wr(7'd7, 32'h10);
        rd(7'd7, 32'h10, "R3 type lo");

        // R4: threshold and control
        wr(7'd1, 32'hFFFF_FFE3);
        rd(7'd1, 32'h3, "R4 thresh low bits");
        wr(7'd0, 32'h0000_005A);
        rd(7'd0, 32'h5A, "R4 ctrl");

        // R5: reversed priority words
        wr(7'd15, 32'h0000_0070);
        rd(7'd15, 32'h70, "R5 prio word0");
        wr(7'd8, 32'h9000_0000);
        rd(7'd8, 32'h9000_0000, "R5 prio word7");
        rd(7'd14, 32'h0, "R5 prio word1 untouched");

        // R1 and R7: normal source 1 (prio 7), threshold 3
        @(negedge clk); src[1] = 1'b1;
        tick(2);
        chk("R7 norm above thresh", irq_norm, 1'b1);
        rd(7'd19, 32'h2, "R1 rise sets pending");
        @(negedge clk); src[1] = 1'b0;
        tick(2);
        chk("R7 norm drops", irq_norm, 1'b0);
        rd(7'd19, 32'h0, "R1 fall clears pending");
        @(negedge clk); src[1] = 1'b1;
        tick(2);
        wr(7'd1, 32'd7);
        tick(1);
        chk("R7 prio equal thresh", irq_norm, 1'b0);
        wr(7'd1, 32'd31);
        tick(1);
        chk("R7 thresh 31 passes", irq_norm, 1'b1);
        wr(7'd1, 32'd3);
        rd(7'd23, 32'h2, "R10 normal pending lo");
        rd(7'd22, 32'h0, "R10 normal pending hi");
        rd(7'd25, 32'h0, "R10 fast pending lo empty");

        // R6 and R9: fast source 4
        @(negedge clk); src[4] = 1'b1;
        tick(2);
        chk("R6 fast up", irq_fast, 1'b1);
        rd(7'd25, 32'h10, "R10 fast pending lo");
        rd(7'd17, 32'd4, "R9 fast vector");
        tick(1);
        chk("R6 fast down after ack", irq_fast, 1'b0);
        rd(7'd17, 32'hFFFF_FFFF, "R9 fast empty");
        rd(7'd19, 32'h2, "R9 ack cleared only src4");
        @(negedge clk); src[4] = 1'b0;
        wr(7'd7, 32'h210);
        @(negedge clk); src[4] = 1'b1; src[9] = 1'b1;
        tick(2);
        chk("R6 fast two sources", irq_fast, 1'b1);
        rd(7'd17, 32'd4, "R9 lowest first");
        rd(7'd17, 32'd9, "R9 next");
        tick(1);
        chk("R6 fast drained", irq_fast, 1'b0);

        // R8: normal vector ordering
        wr(7'd4, 32'h8000_0000);
        @(negedge clk); src[63] = 1'b1;
        tick(2);
        rd(7'd16, 32'h003F_0009, "R8 highest prio");
        rd(7'd16, 32'h0001_0007, "R8 second");
        rd(7'd16, 32'hFFFF_FFFF, "R8 empty");
        tick(1);
        chk("R7 norm idle after drain", irq_norm, 1'b0);
        @(negedge clk); src[2] = 1'b1; src[3] = 1'b1;
        tick(2);
        chk("R7 prio0 below thresh", irq_norm, 1'b0);
        rd(7'd16, 32'h0003_0000, "R8 tie higher number");
        rd(7'd16, 32'h0002_0000, "R8 tie remaining");

        // R10: overwrite and ignored writes
        wr(7'd21, 32'h110);
        rd(7'd19, 32'h110, "R10 overwrite lo");
        rd(7'd25, 32'h10, "R10 fast pending lo");
        rd(7'd23, 32'h100, "R10 normal pending lo");
        wr(7'd20, 32'h1);
        rd(7'd18, 32'h1, "R10 overwrite hi");
        rd(7'd22, 32'h0, "R10 disabled hi not normal pending");
        wr(7'd19, 32'hABCD);
        rd(7'd19, 32'h110, "R10 raw write ignored");
        wr(7'd16, 32'h0);
        wr(7'd25, 32'hFFFF);
        rd(7'd18, 32'h1, "R10 vector write ignored");
        rd(7'd25, 32'h10, "R10 pending-view write ignored");
        chk("R6 forced fast", irq_fast, 1'b1);

        // R12: acknowledge beats rising input in the same cycle
        @(negedge clk); src[4] = 1'b0;
        wr(7'd21, 32'h10);
        @(negedge clk);
        src[4] = 1'b1; rd_en = 1'b1; addr = 7'd17;
        exp_q.push_back(32'd4); tag_q.push_back("R12 ack with rise");
        @(negedge clk); rd_en = 1'b0;
        rd(7'd19, 32'h0, "R12 ack wins over rise");
        chk("R12 fast low after ack", irq_fast, 1'b0);

        // R11: reset again clears configuration
        @(negedge clk); src = '0;
        tick(2);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        rd(7'd5, 32'h0, "R11 enable cleared");
        rd(7'd7, 32'h0, "R11 type cleared");
        rd(7'd8, 32'h0, "R11 prio cleared");
        rd(7'd1, 32'h0, "R11 thresh cleared");
        rd(7'd18, 32'h0, "R11 pending cleared");
        rd(7'd0, 32'h0, "R11 ctrl cleared");
        tick(2);
        finish_run();
    end
endmodule